// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Preload

This block is one capture/compare channel that sits beside a free-running timer counter. In output direction, software writes a compare value into a holding (preload) register. That value goes into the live compare register at once, or only when the timer signals an update event, depending on a preload-enable input. The live value is compared with the counter every clock. A match gives a one-cycle match pulse and drives the channel pin.

In input direction the same live register becomes a capture latch. A capture strobe stores the current counter value there. Bus writes to the channel are then discarded, and a read returns the captured count. In output direction a read returns the holding register, so software always sees what it last wrote, whether or not an update event has copied it yet. The counter, edge detection and filtering of the capture source, and any interrupt logic live outside the block.

Top module: `tmr_cc_channel`

## Requirements
- R1: While reset is asserted, `rd_data`, `cmp_match` and `cmp_pin` are all 0. The holding and live registers reset to 0.
- R2: In output direction (`dir_in`=0) with `preload_en`=0, a write loads `wr_data` into the live register at the same clock edge.
- R3: In output direction with `preload_en`=1, a write loads only the holding register. The live register takes the holding value at the edge where `update_evt`=1.
- R4: With `preload_en`=0, an `update_evt` pulse leaves the live register unchanged.
- R5: In output direction, `cmp_match` is 1 for exactly the clock after an edge at which `counter` equalled the live register. Otherwise it is 0.
- R6: With `PIN_TOGGLE`=1, `cmp_pin` inverts at each edge where a match is registered. It holds its value at every other edge.
- R7: In output direction, `rd_data` shows the holding register, not the live register.
- R8: In input direction (`dir_in`=1), a `capture_stb` stores `counter` in the live register. `rd_data` then shows that captured value.
- R9: In input direction, writes change neither the holding nor the live register. A read taken after returning to output direction still shows the earlier holding value.
- R10: In input direction, when a capture strobe and a write arrive at the same edge, the capture value is stored.
- R11: With `preload_en`=1, when a write and an update event arrive at the same edge, the live register takes the old holding value, and the holding register takes the new write data.
- R12: In input direction, `cmp_match` stays 0 whatever the counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_in | input | 1 | Channel direction: 0 output compare, 1 input capture |
| preload_en | input | 1 | 1: writes wait for an update event before reaching the live register |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | CNT_W | Register write data |
| rd_data | output | CNT_W | Register read data (holding value in output direction, captured value in input direction) |
| counter | input | CNT_W | Timer counter value |
| update_evt | input | 1 | One-cycle timer update event |
| capture_stb | input | 1 | One-cycle capture strobe |
| cmp_match | output | 1 | Registered one-cycle compare match pulse |
| cmp_pin | output | 1 | Channel output pin |

## Verification
The bench builds the channel with `CNT_W`=4 and `PIN_TOGGLE`=1. With only sixteen counter values, it can load every possible compare value and run the counter through every count against each one. This covers every equality and non-equality case and every pin toggle. The same narrow width lets it capture at every counter value in input direction. It also covers the same-edge collisions of write with update and of write with capture.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

   typedef enum logic {
      DIR_OUT = 1'b0,
      DIR_IN  = 1'b1
   } ch_dir_e;

   typedef struct packed {
      logic ld_capture;
      logic ld_direct;
      logic ld_transfer;
   } live_ctl_t;

endpackage

// File: rtl/tmr_cc_ctl.sv
module tmr_cc_ctl
   import tmr_cc_pkg::*;
(
   input  ch_dir_e   dir,
   input  logic      preload_en,
   input  logic      wr_en,
   input  logic      update_evt,
   input  logic      capture_stb,
   output logic      hold_we,
   output live_ctl_t live_ctl
);

   logic is_out;

   always_comb begin
      is_out               = (dir == DIR_OUT);
      hold_we              = is_out & wr_en;
      live_ctl.ld_capture  = ~is_out & capture_stb;
      live_ctl.ld_direct   = is_out & wr_en & ~preload_en;
      live_ctl.ld_transfer = is_out & update_evt & preload_en;
   end

endmodule

// File: rtl/tmr_cc_store.sv
module tmr_cc_store
   import tmr_cc_pkg::*;
#(
   parameter int unsigned W       = 16,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold_we,
   input  live_ctl_t    live_ctl,
   input  logic [W-1:0] wr_data,
   input  logic [W-1:0] counter,
   output logic [W-1:0] hold_q,
   output logic [W-1:0] live_q
);

   logic [W-1:0] live_d;

   always_comb begin
      live_d = live_q;
      if (live_ctl.ld_capture)
         live_d = counter;
      else if (live_ctl.ld_direct)
         live_d = wr_data;
      else if (live_ctl.ld_transfer)
         live_d = hold_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= RST_VAL;
         live_q <= RST_VAL;
      end else begin
         if (hold_we)
            hold_q <= wr_data;
         live_q <= live_d;
      end
   end

endmodule

// File: rtl/tmr_cc_cmp.sv
module tmr_cc_cmp #(
   parameter int unsigned W          = 16,
   parameter bit          PIN_TOGGLE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmp_en,
   input  logic [W-1:0] counter,
   input  logic [W-1:0] live_q,
   output logic         match_q,
   output logic         pin_q
);

   logic hit;

   always_comb hit = cmp_en & (counter == live_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         match_q <= 1'b0;
      else
         match_q <= hit;
   end

   generate
      if (PIN_TOGGLE) begin : g_pin_toggle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pin_q <= 1'b0;
            else if (hit)
               pin_q <= ~pin_q;
         end
      end else begin : g_pin_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pin_q <= 1'b0;
            else
               pin_q <= hit;
         end
      end
   endgenerate

endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel
   import tmr_cc_pkg::*;
#(
   parameter int unsigned CNT_W      = 16,
   parameter bit          PIN_TOGGLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dir_in,
   input  logic             preload_en,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] rd_data,
   input  logic [CNT_W-1:0] counter,
   input  logic             update_evt,
   input  logic             capture_stb,
   output logic             cmp_match,
   output logic             cmp_pin
);

   localparam logic [CNT_W-1:0] RST_VAL = '0;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("tmr_cc_channel: CNT_W must lie in 2..32");
      end
   endgenerate

   ch_dir_e      dir;
   logic         hold_we;
   live_ctl_t    live_ctl;
   logic [CNT_W-1:0] hold_q;
   logic [CNT_W-1:0] live_q;

   always_comb dir = dir_in ? DIR_IN : DIR_OUT;

   tmr_cc_ctl u_ctl (
      .dir         (dir),
      .preload_en  (preload_en),
      .wr_en       (wr_en),
      .update_evt  (update_evt),
      .capture_stb (capture_stb),
      .hold_we     (hold_we),
      .live_ctl    (live_ctl)
   );

   tmr_cc_store #(
      .W       (CNT_W),
      .RST_VAL (RST_VAL)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_we  (hold_we),
      .live_ctl (live_ctl),
      .wr_data  (wr_data),
      .counter  (counter),
      .hold_q   (hold_q),
      .live_q   (live_q)
   );

   tmr_cc_cmp #(
      .W          (CNT_W),
      .PIN_TOGGLE (PIN_TOGGLE)
   ) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmp_en  (dir == DIR_OUT),
      .counter (counter),
      .live_q  (live_q),
      .match_q (cmp_match),
      .pin_q   (cmp_pin)
   );

   always_comb rd_data = (dir == DIR_IN) ? live_q : hold_q;

endmodule

// File: rtl/tmr_cc_channel_chk.sv
module tmr_cc_channel_chk #(
   parameter int unsigned CNT_W      = 16,
   parameter bit          PIN_TOGGLE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dir_in,
   input logic             preload_en,
   input logic             wr_en,
   input logic [CNT_W-1:0] wr_data,
   input logic [CNT_W-1:0] rd_data,
   input logic [CNT_W-1:0] counter,
   input logic             update_evt,
   input logic             capture_stb,
   input logic             cmp_match,
   input logic             cmp_pin,
   input logic [CNT_W-1:0] live_q
);

   assert_direct_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_in && wr_en && !preload_en) |=> (live_q == $past(wr_data)));

   assert_live_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_in && !(wr_en && !preload_en) && !(update_evt && preload_en)) |=> $stable(live_q));

   assert_no_match_input_R12: assert property (@(posedge clk) disable iff (!rst_n)
      dir_in |=> !cmp_match);

   assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_in && wr_en) |=> (dir_in || rd_data == $past(wr_data)));

   assert_capture_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_in && capture_stb) |=> (!dir_in || rd_data == $past(counter)));

   assert_input_readonly_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_in && !capture_stb) |=> (!dir_in || $stable(rd_data)));

   generate
      if (PIN_TOGGLE) begin : g_pin_chk
         assert_pin_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_pin != $past(cmp_pin)) == cmp_match);
      end
   endgenerate

endmodule

bind tmr_cc_channel tmr_cc_channel_chk #(
   .CNT_W      (CNT_W),
   .PIN_TOGGLE (PIN_TOGGLE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dir_in      (dir_in),
   .preload_en  (preload_en),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .rd_data     (rd_data),
   .counter     (counter),
   .update_evt  (update_evt),
   .capture_stb (capture_stb),
   .cmp_match   (cmp_match),
   .cmp_pin     (cmp_pin),
   .live_q      (live_q)
);

// File: tb/tmr_cc_channel_tb_top.sv
module tmr_cc_channel_tb_top;

   localparam int unsigned W = 4;
   localparam int unsigned N = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         dir_in = 1'b0;
   logic         preload_en = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic [W-1:0] counter = '0;
   logic         update_evt = 1'b0;
   logic         capture_stb = 1'b0;
   logic         cmp_match;
   logic         cmp_pin;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [W-1:0] m_hold = '0;
   logic [W-1:0] m_live = '0;
   logic         m_pin = 1'b0;
   logic         m_match = 1'b0;

   always #10 clk = ~clk;

   tmr_cc_channel #(.CNT_W(W), .PIN_TOGGLE(1'b1)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .dir_in      (dir_in),
      .preload_en  (preload_en),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .rd_data     (rd_data),
      .counter     (counter),
      .update_evt  (update_evt),
      .capture_stb (capture_stb),
      .cmp_match   (cmp_match),
      .cmp_pin     (cmp_pin)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   // Drive one cycle at the falling edge, advance the model at the rising edge, check at the next falling edge.
   task automatic cyc(input logic w, input logic [W-1:0] d, input logic u,
                      input logic c, input logic m, input logic p,
                      input logic [W-1:0] k, input string tag);
      logic [W-1:0] nx_live;
      wr_en = w; wr_data = d; update_evt = u; capture_stb = c;
      dir_in = m; preload_en = p; counter = k;
      @(posedge clk);
      m_match = !m && (k == m_live);
      if (m_match) m_pin = ~m_pin;
      nx_live = m_live;
      if (m && c)            nx_live = k;
      else if (!m && w && !p) nx_live = d;
      else if (!m && u && p)  nx_live = m_hold;
      if (!m && w) m_hold = d;
      m_live = nx_live;
      @(negedge clk);
      check(tag, int'(rd_data), m ? int'(m_live) : int'(m_hold));
      check(m ? "R12 match" : "R5 match", int'(cmp_match), int'(m_match));
      check("R6 pin", int'(cmp_pin), int'(m_pin));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 rd", int'(rd_data), 0);
      check("R1 match", int'(cmp_match), 0);
      check("R1 pin", int'(cmp_pin), 0);
      rst_n = 1'b1;

      // R2: direct load, every compare value against every count
      for (int v = 0; v < N; v++) begin
         cyc(1'b1, W'(v), 1'b0, 1'b0, 1'b0, 1'b0, W'(v + 3), "R2 rd");
         for (int k = 0; k < N; k++)
            cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, W'(k), "R7 rd");
      end

      // R3: held write reaches live only on update
      cyc(1'b1, W'(5), 1'b0, 1'b0, 1'b0, 1'b1, W'(0), "R7 rd");
      for (int k = 0; k < N; k++)
         cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, W'(k), "R3 rd");
      cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b1, W'(0), "R3 rd");
      for (int k = 0; k < N; k++)
         cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, W'(k), "R3 rd");

      // R11: write and update on the same edge
      cyc(1'b1, W'(9), 1'b1, 1'b0, 1'b0, 1'b1, W'(1), "R11 rd");
      for (int k = 0; k < N; k++)
         cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, W'(k), "R11 rd");

      // R4: update without preload leaves live alone (hold=9, live=5)
      for (int k = 0; k < N; k++)
         cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, W'(k), "R4 rd");
      for (int k = 0; k < N; k++)
         cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, W'(k), "R4 rd");

      // R8: capture at every count
      for (int k = 0; k < N; k++) begin
         cyc(1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b0, W'(k), "R8 rd");
         cyc(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, W'(k + 7), "R8 rd");
      end

      // R9: writes ignored in input direction
      for (int v = 0; v < N; v++)
         cyc(1'b1, W'(v), 1'b1, 1'b0, 1'b1, v[0], W'(v), "R9 rd");

      // R10: capture wins over a write
      for (int v = 0; v < N; v++)
         cyc(1'b1, W'(v), 1'b0, 1'b1, 1'b1, 1'b0, W'(N - 1 - v), "R10 rd");

      // R9: back to output direction, holding value untouched
      cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, W'(0), "R9 rd");
      for (int k = 0; k < N; k++)
         cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, W'(k), "R9 rd");

      summary();
   end

endmodule